// File: doc/BRIEF.md
# Frame Timing and Hop Scheduler

This block paces the transmit frames of a four-channel frequency-hopping link. After a start pulse it accepts one tick per finished frame. For each tick it gives the delay in microseconds until the next frame, says whether the payload must be rebuilt, and, once per six-frame cycle, moves to the next RF channel. The delay, the channel and the strobes appear one clock after the tick.

After each start the link first runs a fixed-length pairing phase. During this phase a hop picks its channel from an arithmetic ladder (0x30 plus eight times the hop index) rather than from the channel table. The pairing phase is counted in frames. On the frame where the count runs out, the flag drops before that frame's slot is handled, so a hop on that same frame already uses the table. The radio set-up and the microsecond timer that consumes the delay are outside this block.

Top module: `frame_hop_scheduler`

## Requirements
- R1: After reset, and before any start, `next_delay_us_o`, `rf_channel_o`, `rebuild_o`, `chan_change_o` and `bind_active_o` are all zero.
- R2: One cycle after `start_i`, the outputs are: delay 3400, `rebuild_o`=1, `chan_change_o`=1, `rf_channel_o` equal to table entry 0 and `bind_active_o`=1. The slot count and the hop index are cleared. `start_i` has priority over a `frame_tick_i` in the same cycle.
- R3: A `frame_tick_i` that arrives before the first start has no effect on any output.
- R4: Each tick raises the slot count by one. When the new count is 1, 2, 4 or 5, the delay becomes 1183 and neither strobe fires.
- R5: When the new slot count is 3, `rebuild_o` pulses, the delay becomes 3400 and the channel is unchanged.
- R6: When the new slot count is 6, the hop index advances modulo 4 and the slot count returns to 0. `chan_change_o` and `rebuild_o` both pulse and the delay becomes 3400.
- R7: A hop made while pairing is active sets the channel to 0x30 + 8 × (new hop index).
- R8: A hop made outside pairing sets the channel to table entry (new hop index). Entry k occupies bits [8k+7:8k] of `chan_table_i`.
- R9: `bind_active_o` stays high for exactly 2600 ticks after a start and falls on the 2600th tick. That tick's slot logic already treats pairing as over. The flag stays low until the next start.
- R10: `rebuild_o` and `chan_change_o` are single-cycle pulses. In cycles with no tick and no start, the delay and channel outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Initialise the schedule and begin pairing |
| frame_tick_i | input | 1 | One pulse per completed frame |
| chan_table_i | input | 32 | Four 8-bit channels, entry k at bits [8k+7:8k] |
| next_delay_us_o | output | 12 | Microseconds until the next frame |
| rebuild_o | output | 1 | Payload rebuild strobe |
| rf_channel_o | output | 8 | Current RF channel |
| chan_change_o | output | 1 | Channel-change strobe |
| bind_active_o | output | 1 | Pairing phase active |

## Verification
A slot counter that is off by one shows up within one six-frame cycle: a short gap appears where a rebuild was due, or a hop comes at the wrong frame. A hop index that is wrong shows on the very next channel change, because the channel value no longer matches the ladder or the table. A pairing counter that is off by even one frame moves the fall of `bind_active_o` away from tick 2600. That error is visible only at the end of pairing, so the bench runs past that point and compares every clock against a behavioural model.

// File: rtl/frame_sched_pkg.sv
package frame_sched_pkg;
  parameter int CH_W = 8;

  typedef enum logic [1:0] {SLOT_SHORT, SLOT_REBUILD, SLOT_HOP} slot_kind_e;

  // Classify the slot count a tick would move to.
  function automatic slot_kind_e classify_slot(int unsigned nxt, int unsigned cycle,
                                               int unsigned rebuild_slot);
    if (nxt >= cycle)            return SLOT_HOP;
    else if (nxt == rebuild_slot) return SLOT_REBUILD;
    else                          return SLOT_SHORT;
  endfunction

  // Channel used for a hop while pairing.
  function automatic logic [CH_W-1:0] ladder_channel(logic [CH_W-1:0] base,
                                                     int unsigned idx, int unsigned shift);
    logic [CH_W-1:0] step;
    step = CH_W'(idx << shift);
    return base + step;
  endfunction
endpackage

// File: rtl/fsch_slot_seq.sv
module fsch_slot_seq
  import frame_sched_pkg::*;
#(
  parameter int CYCLE        = 6,
  parameter int REBUILD_SLOT = 3,
  parameter int SHORT_US     = 1183,
  parameter int LONG_US      = 3400,
  parameter int DELAY_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               tick_i,
  output logic [DELAY_W-1:0] delay_o,
  output logic               rebuild_o,
  output logic               hop_evt_o
);
  localparam int CNT_W = $clog2(CYCLE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  slot_kind_e       kind;

  assign cnt_nxt   = cnt_q + CNT_W'(1);
  assign kind      = classify_slot(int'(cnt_nxt), CYCLE, REBUILD_SLOT);
  assign hop_evt_o = tick_i && !start_i && (kind == SLOT_HOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      delay_o   <= '0;
      rebuild_o <= 1'b0;
    end else begin
      rebuild_o <= 1'b0;
      if (start_i) begin
        cnt_q     <= '0;
        delay_o   <= DELAY_W'(LONG_US);
        rebuild_o <= 1'b1;
      end else if (tick_i) begin
        unique case (kind)
          SLOT_SHORT: begin
            cnt_q   <= cnt_nxt;
            delay_o <= DELAY_W'(SHORT_US);
          end
          SLOT_REBUILD: begin
            cnt_q     <= cnt_nxt;
            delay_o   <= DELAY_W'(LONG_US);
            rebuild_o <= 1'b1;
          end
          default: begin
            cnt_q     <= '0;
            delay_o   <= DELAY_W'(LONG_US);
            rebuild_o <= 1'b1;
          end
        endcase
      end
    end
  end

  // R6: the slot count never reaches the cycle length
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < CYCLE);
  // R5: a rebuild pulse always comes with the long gap
  p_rebuild_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rebuild_o |-> delay_o == DELAY_W'(LONG_US));
  // R4: a tick without start or hop or rebuild gives the short gap next cycle
  p_short_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !start_i && kind == SLOT_SHORT) |=> (delay_o == DELAY_W'(SHORT_US) && !rebuild_o));
endmodule

// File: rtl/fsch_bind_timer.sv
module fsch_bind_timer #(
  parameter int BIND_FRAMES = 2600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic bind_now_o,
  output logic bind_active_o
);
  localparam int BC_W = $clog2(BIND_FRAMES + 1);

  logic [BC_W-1:0] cnt_q;
  logic            last_frame;

  assign last_frame = tick_i && bind_active_o && (cnt_q == BC_W'(1));
  // Pairing state as seen by this tick's slot logic (countdown first)
  assign bind_now_o = start_i ? 1'b1 : (bind_active_o && !last_frame);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q         <= '0;
      bind_active_o <= 1'b0;
    end else if (start_i) begin
      cnt_q         <= BC_W'(BIND_FRAMES);
      bind_active_o <= 1'b1;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q         <= cnt_q - BC_W'(1);
      bind_active_o <= bind_now_o;
    end
  end

  // R9: the flag is high exactly while frames remain in the countdown
  p_flag_matches_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bind_active_o == (cnt_q != '0));
  // R9: once low it stays low until a start
  p_stays_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bind_active_o && !start_i) |=> !bind_active_o);
endmodule

// File: rtl/fsch_hop_sel.sv
module fsch_hop_sel
  import frame_sched_pkg::*;
#(
  parameter int              NUM_CH     = 4,
  parameter logic [CH_W-1:0] BIND_BASE  = 8'h30,
  parameter int              BIND_SHIFT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   hop_evt_i,
  input  logic                   bind_now_i,
  input  logic [NUM_CH*CH_W-1:0] table_i,
  output logic [CH_W-1:0]        channel_o,
  output logic                   chg_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0]  tbl [NUM_CH];
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
    assign tbl[k] = table_i[k*CH_W +: CH_W];
  end

  assign idx_nxt = (int'(idx_q) == NUM_CH - 1) ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      channel_o <= '0;
      chg_o     <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (start_i) begin
        idx_q     <= '0;
        channel_o <= tbl[0];
        chg_o     <= 1'b1;
      end else if (hop_evt_i) begin
        idx_q     <= idx_nxt;
        channel_o <= bind_now_i ? ladder_channel(BIND_BASE, int'(idx_nxt), BIND_SHIFT)
                                : tbl[idx_nxt];
        chg_o     <= 1'b1;
      end
    end
  end

  // R6: each hop moves the index by exactly one position
  p_index_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_evt_i && !start_i) |=> (idx_q != $past(idx_q)));
  // R7: a pairing hop lands on the ladder grid
  p_ladder_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_evt_i && !start_i && bind_now_i) |=> ((channel_o - BIND_BASE) % (1 << BIND_SHIFT) == 0));
endmodule

// File: rtl/frame_hop_scheduler.sv
module frame_hop_scheduler
  import frame_sched_pkg::*;
#(
  parameter int              NUM_CH       = 4,
  parameter int              CYCLE        = 6,
  parameter int              REBUILD_SLOT = 3,
  parameter int              SHORT_US     = 1183,
  parameter int              LONG_US      = 3400,
  parameter int              DELAY_W      = 12,
  parameter int              BIND_FRAMES  = 2600,
  parameter logic [CH_W-1:0] BIND_BASE    = 8'h30,
  parameter int              BIND_SHIFT   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   frame_tick_i,
  input  logic [NUM_CH*CH_W-1:0] chan_table_i,
  output logic [DELAY_W-1:0]     next_delay_us_o,
  output logic                   rebuild_o,
  output logic [CH_W-1:0]        rf_channel_o,
  output logic                   chan_change_o,
  output logic                   bind_active_o
);
  logic armed_q;
  logic tick_live;
  logic hop_evt;
  logic bind_now;

  always_ff @(posedge clk) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (start_i) armed_q <= 1'b1;
  end

  assign tick_live = frame_tick_i && armed_q;

  fsch_slot_seq #(
    .CYCLE(CYCLE), .REBUILD_SLOT(REBUILD_SLOT), .SHORT_US(SHORT_US),
    .LONG_US(LONG_US), .DELAY_W(DELAY_W)
  ) slot_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_live),
    .delay_o(next_delay_us_o), .rebuild_o(rebuild_o), .hop_evt_o(hop_evt)
  );

  fsch_bind_timer #(.BIND_FRAMES(BIND_FRAMES)) bind_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_live),
    .bind_now_o(bind_now), .bind_active_o(bind_active_o)
  );

  fsch_hop_sel #(
    .NUM_CH(NUM_CH), .BIND_BASE(BIND_BASE), .BIND_SHIFT(BIND_SHIFT)
  ) hop_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hop_evt_i(hop_evt),
    .bind_now_i(bind_now), .table_i(chan_table_i),
    .channel_o(rf_channel_o), .chg_o(chan_change_o)
  );

  // R6: every channel change comes with a rebuild
  p_change_rebuilds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_change_o |-> rebuild_o);
  // R10: quiet cycles produce no strobe
  p_quiet_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick_i && !start_i) |=> (!rebuild_o && !chan_change_o));
  // R10: outputs hold across quiet cycles
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick_i && !start_i) |=> ($stable(next_delay_us_o) && $stable(rf_channel_o)));
  // R3: ticks before the first start change nothing
  p_unarmed_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i) |=> (!rebuild_o && !chan_change_o && !bind_active_o));
  // R2: start yields a change and a rebuild with pairing active
  p_start_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (chan_change_o && rebuild_o && bind_active_o));
endmodule

// File: tb/frame_hop_scheduler_tb.sv
`timescale 1ns/1ps
module frame_hop_scheduler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        frame_tick_i = 1'b0;
  logic [31:0] chan_table_i;
  logic [11:0] next_delay_us_o;
  logic        rebuild_o;
  logic [7:0]  rf_channel_o;
  logic        chan_change_o;
  logic        bind_active_o;

  always #2.5 clk = ~clk;

  frame_hop_scheduler dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_tick_i(frame_tick_i),
    .chan_table_i(chan_table_i), .next_delay_us_o(next_delay_us_o),
    .rebuild_o(rebuild_o), .rf_channel_o(rf_channel_o),
    .chan_change_o(chan_change_o), .bind_active_o(bind_active_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state
  int tbl[4];
  int m_cnt = 0, m_idx = 0, m_bindc = 0;
  bit m_bind = 0, m_armed = 0;
  int m_delay = 0, m_ch = 0;
  bit m_reb = 0, m_chg = 0;
  int ticks_since_start = 0;
  int bind_fall_tick = -1;

  function automatic logic [31:0] pack_tbl();
    return {tbl[3][7:0], tbl[2][7:0], tbl[1][7:0], tbl[0][7:0]};
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit s, bit t);
    string tag;
    bit prev_bind;
    @(negedge clk);
    start_i = s;
    frame_tick_i = t;
    chan_table_i = pack_tbl();
    @(posedge clk);
    #1;
    start_i = 1'b0;
    frame_tick_i = 1'b0;
    m_reb = 0;
    m_chg = 0;
    prev_bind = m_bind;
    if (s) begin
      tag = "R2";
      m_armed = 1; m_cnt = 0; m_idx = 0; m_bindc = 2600; m_bind = 1;
      m_delay = 3400; m_reb = 1; m_ch = tbl[0]; m_chg = 1;
      ticks_since_start = 0; bind_fall_tick = -1;
    end else if (t && m_armed) begin
      ticks_since_start++;
      if (m_bindc > 0) begin
        m_bindc--;
        if (m_bindc == 0) m_bind = 0;
      end
      m_cnt++;
      if (m_cnt == 3) begin
        tag = "R5"; m_delay = 3400; m_reb = 1;
      end else if (m_cnt < 6) begin
        tag = "R4"; m_delay = 1183;
      end else begin
        m_idx = (m_idx + 1) % 4;
        m_ch = m_bind ? (8'h30 + 8 * m_idx) : tbl[m_idx];
        tag = m_bind ? "R6/R7" : "R6/R8";
        m_cnt = 0; m_delay = 3400; m_reb = 1; m_chg = 1;
      end
    end else if (t) begin
      tag = "R3";
    end else begin
      tag = "R10";
    end
    if (prev_bind && !m_bind) bind_fall_tick = ticks_since_start;
    check(tag, next_delay_us_o, m_delay, "delay");
    check(tag, rf_channel_o, m_ch, "channel");
    check(tag, rebuild_o, m_reb, "rebuild");
    check(tag, chan_change_o, m_chg, "chan_change");
    check("R9", bind_active_o, m_bind, "bind_active");
  endtask

  initial begin
    tbl[0] = 8'h30; tbl[1] = 8'h45; tbl[2] = 8'h40; tbl[3] = 8'h35;
    chan_table_i = pack_tbl();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", next_delay_us_o, 0, "delay");
    check("R1", rf_channel_o, 0, "channel");
    check("R1", rebuild_o, 0, "rebuild");
    check("R1", chan_change_o, 0, "chan_change");
    check("R1", bind_active_o, 0, "bind_active");
    @(negedge clk);
    rst_n = 1'b1;
    // R3: ticks before start
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    // Run through pairing into normal hopping, varying gaps
    for (int f = 0; f < 2700; f++) begin
      step(1'b0, 1'b1);
      for (int g = 0; g < f % 3; g++) step(1'b0, 1'b0);
    end
    // R9: pairing ended exactly at tick 2600
    check("R9", bind_fall_tick, 2600, "bind fall tick");
    // R8: new table contents
    tbl[0] = 8'h11; tbl[1] = 8'h22; tbl[2] = 8'h33; tbl[3] = 8'h44;
    for (int f = 0; f < 30; f++) step(1'b0, 1'b1);
    // R2: restart together with a tick, mid-cycle
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int f = 0; f < 40; f++) step(1'b0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule